// File: doc/BRIEF.md
# Streaming Word-Sum Checksum Unit

This block forms a frame checksum by adding fixed-width words (16 bits by default) as they stream in. Each beat carries a word, a valid flag and a last flag. The mode is taken from the first beat of a frame. In generate mode the block adds every word of the frame and then presents the two's-complement negation of the total. The sender appends that value to the frame as its trailer word.

In check mode the beat marked last is the received trailer. The block adds it into the same running total as the data words. Because the sender negated its sum, a clean frame totals exactly zero. The receiver therefore only needs a wide NOR across the total, not a comparison of two sums. The result registers and a one-cycle done strobe update one clock after the last beat. A start pulse drops any partial frame.

Top module: `cks_stream_unit`

## Requirements
- R1: While reset is high and in the cycle after it, out_done, out_word, out_pass and out_err are all zero.
- R2: Generate mode (mode_in = 0) adds every valid word of the frame, the last beat included, modulo 2^16. out_word then becomes the two's complement of that total, (~total + 1) mod 2^16.
- R3: Check mode (mode_in = 1) adds every valid word, the last beat (trailer) included, modulo 2^16. When the total is zero, out_pass = 1, out_err = 0 and out_word = 0.
- R4: In check mode a nonzero total gives out_err = 1 and out_pass = 0, and out_word shows that nonzero total.
- R5: out_done is high for exactly the one cycle after each beat with in_valid and in_last both high, and out_word, out_pass and out_err take their new values in that same cycle.
- R6: The first valid beat after reset or after a last beat starts a new frame from a zero total, so back-to-back frames do not affect each other.
- R7: A start pulse discards any partial frame. A valid beat in the same cycle as the start pulse is the first word of the new frame.
- R8: mode_in is sampled only on the first beat of a frame. Changes during the rest of the frame have no effect.
- R9: Cycles with in_valid low add nothing to the total. out_word, out_pass and out_err hold their values until the next done strobe.
- R10: In generate mode out_pass and out_err are both 0.
- R11: A single-beat frame is valid. In generate mode its trailer is the negation of that word. In check mode it passes only when the word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Discard any partial frame; begin a new one |
| mode_in | input | 1 | 0 = generate trailer, 1 = check frame (sampled on first beat) |
| in_valid | input | 1 | Beat carries a word |
| in_last | input | 1 | Beat is the final one of the frame |
| in_word | input | 16 | Data or trailer word |
| out_done | output | 1 | One-cycle strobe after the last beat |
| out_word | output | 16 | Generated trailer, or total in check mode |
| out_pass | output | 1 | Check-mode frame totalled zero |
| out_err | output | 1 | Check-mode frame totalled nonzero |

## Verification
The embedded properties check on every cycle the handshake timing: out_done follows each last beat by exactly one cycle and appears at no other time. They also check that the results hold between strobes, that pass and error never rise together, and that a pass always shows a zero word. Only the directed scenarios can show the arithmetic itself. These cover the negated sum with carry wrap-off, trailer round trips, corrupted frames and single-beat frames. They also show that idle beats, mid-frame mode changes and aborted partial frames leave the total untouched.

// File: rtl/cks_pkg.sv
package cks_pkg;
  typedef enum logic {
    MODE_GEN = 1'b0,
    MODE_CHK = 1'b1
  } cks_mode_e;
endpackage

// File: rtl/cks_frame_ctl.sv
module cks_frame_ctl
  import cks_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start_i,
  input  logic      valid_i,
  input  logic      last_i,
  input  logic      mode_i,
  output logic      first_o,
  output cks_mode_e mode_o
);
  logic      open_q;
  cks_mode_e mode_q;

  // a beat opens a frame when none is open or a start pulse is present
  assign first_o = start_i | ~open_q;
  assign mode_o  = first_o ? cks_mode_e'(mode_i) : mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      mode_q <= MODE_GEN;
    end else if (valid_i) begin
      open_q <= ~last_i;
      mode_q <= mode_o;
    end else if (start_i) begin
      open_q <= 1'b0;
    end
  end

  // R8: mode is locked while a frame is open and no start arrives
  a_r8_mode_locked: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !last_i) |=> (!start_i -> (mode_o == $past(mode_o))));
endmodule

// File: rtl/cks_accum.sv
module cks_accum #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              first_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] sum_o
);
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] base;

  assign base  = first_i ? '0 : acc_q;
  assign sum_o = base + word_i;

  always_ff @(posedge clk) begin
    if (rst)          acc_q <= '0;
    else if (valid_i) acc_q <= sum_o;
  end

  // R9: idle cycles leave the running total alone
  a_r9_idle_no_add: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(acc_q));
endmodule

// File: rtl/cks_result.sv
module cks_result
  import cks_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire_i,
  input  cks_mode_e         mode_i,
  input  logic [WORD_W-1:0] sum_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic              pass_o,
  output logic              err_o
);
  logic zero_total;
  assign zero_total = ~|sum_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0;
      word_o <= '0;
      pass_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= fire_i;
      if (fire_i) begin
        if (mode_i == MODE_GEN) begin
          word_o <= ~sum_i + 1'b1;
          pass_o <= 1'b0;
          err_o  <= 1'b0;
        end else begin
          word_o <= sum_i;
          pass_o <= zero_total;
          err_o  <= ~zero_total;
        end
      end
    end
  end

  // R4: pass and error are never raised together
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pass_o && err_o));
  // R3: a passing frame always reports a zero residue
  a_r3_pass_zero: assert property (@(posedge clk) disable iff (rst)
    pass_o |-> (word_o == '0));
endmodule

// File: rtl/cks_stream_unit.sv
module cks_stream_unit
  import cks_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_in,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_done,
  output logic [WORD_W-1:0] out_word,
  output logic              out_pass,
  output logic              out_err
);
  logic              first;
  cks_mode_e         mode_eff;
  logic [WORD_W-1:0] sum_next;
  logic              fire;

  assign fire = in_valid & in_last;

  cks_frame_ctl u_ctl (
    .clk    (clk),
    .rst    (rst),
    .start_i(start),
    .valid_i(in_valid),
    .last_i (in_last),
    .mode_i (mode_in),
    .first_o(first),
    .mode_o (mode_eff)
  );

  cks_accum #(.WORD_W(WORD_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .first_i(first),
    .valid_i(in_valid),
    .word_i (in_word),
    .sum_o  (sum_next)
  );

  cks_result #(.WORD_W(WORD_W)) u_res (
    .clk   (clk),
    .rst   (rst),
    .fire_i(fire),
    .mode_i(mode_eff),
    .sum_i (sum_next),
    .done_o(out_done),
    .word_o(out_word),
    .pass_o(out_pass),
    .err_o (out_err)
  );

  // R5: a last beat is answered by done one cycle later
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> out_done);
  // R5: done never appears without a preceding last beat
  a_r5_done_cause: assert property (@(posedge clk) disable iff (rst)
    out_done |-> $past(in_valid && in_last));
  // R9: results hold between strobes
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !out_done |-> $stable({out_word, out_pass, out_err}));
endmodule

// File: tb/tb_cks_stream_unit.sv
module tb_cks_stream_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic         mode_in;
  logic         in_valid;
  logic         in_last;
  logic [W-1:0] in_word;
  logic         out_done;
  logic [W-1:0] out_word;
  logic         out_pass;
  logic         out_err;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] frm [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  cks_stream_unit #(.WORD_W(W)) dut (
    .clk(clk), .rst(rst), .start(start), .mode_in(mode_in),
    .in_valid(in_valid), .in_last(in_last), .in_word(in_word),
    .out_done(out_done), .out_word(out_word),
    .out_pass(out_pass), .out_err(out_err)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    in_valid = 1'b0; in_last = 1'b0; start = 1'b0; in_word = 16'hDEAD;
    @(negedge clk);
  endtask

  // one beat driven after a negedge, captured at the following posedge
  task automatic beat(input logic m, input logic [W-1:0] w, input logic l);
    mode_in = m; in_valid = 1'b1; in_last = l; in_word = w; start = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic send(input logic m, input int n);
    for (int i = 0; i < n; i++) beat(m, frm[i], i == n-1);
  endtask

  function automatic logic [W-1:0] total(input int n);
    logic [W-1:0] s = '0;
    for (int i = 0; i < n; i++) s = s + frm[i];
    return s;
  endfunction

  task automatic expect_out(input string req, input logic [W-1:0] w, input logic p, input logic e);
    chk(out_done == 1'b1, {req, " done"}, {31'd0, out_done}, 32'd1);
    chk(out_word == w, {req, " word"}, {16'd0, out_word}, {16'd0, w});
    chk(out_pass == p && out_err == e, {req, " flags"}, {30'd0, out_pass, out_err}, {30'd0, p, e});
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0; mode_in = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_word = '0;
    repeat (3) @(negedge clk);
    chk({out_done, out_word, out_pass, out_err} == '0, "R1 during reset", {13'd0, out_done, out_word, out_pass, out_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({out_done, out_word, out_pass, out_err} == '0, "R1 after reset", {13'd0, out_done, out_word, out_pass, out_err}, 0);
  endtask

  task automatic t_generate();
    logic [W-1:0] t;
    frm[0] = 16'hFFFF; frm[1] = 16'h0003; frm[2] = 16'h8000; frm[3] = 16'h9001;
    send(1'b0, 4);
    t = ~total(4) + 1'b1;
    expect_out("R2 R10 generate", t, 1'b0, 1'b0);
    idle();
    chk(out_done == 1'b0, "R5 done single cycle", {31'd0, out_done}, 0);
    chk(out_word == t, "R9 hold after done", {16'd0, out_word}, {16'd0, t});
  endtask

  task automatic t_check_good();
    frm[0] = 16'h1234; frm[1] = 16'hABCD; frm[2] = 16'h0F0F;
    frm[3] = ~total(3) + 1'b1;
    send(1'b1, 4);
    expect_out("R3 check pass", 16'h0000, 1'b1, 1'b0);
  endtask

  task automatic t_check_bad();
    logic [W-1:0] t;
    frm[0] = 16'h1234; frm[1] = 16'hABCD; frm[2] = 16'h0F0F;
    frm[3] = ~total(3) + 1'b1;
    frm[1] = frm[1] ^ 16'h0300;
    t = total(4);
    send(1'b1, 4);
    expect_out("R4 check corrupt", t, 1'b0, 1'b1);
  endtask

  task automatic t_gaps();
    logic [W-1:0] t;
    frm[0] = 16'h0101; frm[1] = 16'h2020; frm[2] = 16'h4444;
    t = ~total(3) + 1'b1;
    beat(1'b0, frm[0], 1'b0);
    idle(); idle();
    chk(out_done == 1'b0, "R9 no done on idle", {31'd0, out_done}, 0);
    beat(1'b0, frm[1], 1'b0);
    idle();
    beat(1'b0, frm[2], 1'b1);
    expect_out("R9 idle beats not added", t, 1'b0, 1'b0);
  endtask

  task automatic t_mode_change();
    logic [W-1:0] t;
    frm[0] = 16'h0010; frm[1] = 16'h0020; frm[2] = 16'h0030;
    t = ~total(3) + 1'b1;
    beat(1'b0, frm[0], 1'b0);
    beat(1'b1, frm[1], 1'b0);
    beat(1'b1, frm[2], 1'b1);
    expect_out("R8 mode held from first beat", t, 1'b0, 1'b0);
  endtask

  task automatic t_start();
    frm[0] = 16'h5555; frm[1] = 16'hAAAA;
    beat(1'b1, 16'h7777, 1'b0);
    beat(1'b1, 16'h1111, 1'b0);
    start = 1'b1; in_valid = 1'b0; @(negedge clk); start = 1'b0;
    frm[1] = ~frm[0] + 1'b1;
    send(1'b1, 2);
    expect_out("R7 start drops partial", 16'h0000, 1'b1, 1'b0);
    beat(1'b1, 16'h2222, 1'b0);
    mode_in = 1'b0; start = 1'b1; in_valid = 1'b1; in_last = 1'b0; in_word = 16'h0100;
    @(negedge clk);
    start = 1'b0;
    beat(1'b1, 16'h0001, 1'b1);
    expect_out("R7 start with beat", 16'hFEFF, 1'b0, 1'b0);
  endtask

  task automatic t_single_and_b2b();
    beat(1'b0, 16'h1234, 1'b1);
    expect_out("R11 single gen", 16'hEDCC, 1'b0, 1'b0);
    beat(1'b1, 16'h0000, 1'b1);
    expect_out("R11 single check zero R6", 16'h0000, 1'b1, 1'b0);
    beat(1'b1, 16'h0040, 1'b1);
    expect_out("R11 single check nonzero R6", 16'h0040, 1'b0, 1'b1);
    frm[0] = 16'h0003; frm[1] = 16'hFFFD;
    send(1'b1, 2);
    expect_out("R6 back to back", 16'h0000, 1'b1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_generate();
    t_check_good();
    t_check_bad();
    t_gaps();
    t_mode_change();
    t_start();
    t_single_and_b2b();
    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule